// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight interrupt request lines, latches their rising edges, masks them, and picks the lowest-numbered line as the most urgent. It raises a single interrupt output toward the processor. When the processor acknowledges, it returns a vector byte and moves the chosen line from the pending set to the in-service set. Software clears in-service levels later with end-of-interrupt commands.

Software talks to the block through a byte-wide register port with a one-bit address that selects an even or an odd port. A multi-word setup sequence comes first. Its opening word goes to the even port, and that word decides whether the third and fourth words follow on the odd port. After setup, odd-port writes load the mask. Even-port writes carry end-of-interrupt commands or choose which register an even-port read returns. Reads are combinational.

Top module: `prio_intc`

## Requirements
- R1: After reset the interrupt output and vec_valid are low, vec_out is zero, and both ports read back zero.
- R2: An even-port write with bit 4 set starts setup. The next odd write gives the vector base in bits 7..3. A slave-map word follows only if bit 1 of the opening word was 0. A mode word follows only if bit 0 was 1. The interrupt output stays low until the last expected word is written.
- R3: The opening setup word clears the mask, the request register and the in-service register. It also selects the request register for even reads and turns off automatic end-of-interrupt and special nesting.
- R4: A rising edge on irq_in[n] sets request bit n at the next clock. A line held high does not set the bit again after it has been cleared.
- R5: After setup, an odd-port write loads the mask, and an odd-port read returns it. Mask bit n set to 1 keeps line n from raising the interrupt, but its request bit stays latched.
- R6: Line 0 has the highest priority. The interrupt output is high when the most urgent unmasked pending line is strictly more urgent than every in-service level.
- R7: A one-cycle inta while the interrupt output is high gives vec_valid for exactly the next cycle, with vec_out = {base[4:0], line[2:0]}. It also clears that line's request bit and sets its in-service bit. vec_out is zero whenever vec_valid is low.
- R8: An inta while the interrupt output is low returns line number 7 in the vector and changes neither register.
- R9: An even write with bits 4..3 = 00 is a command. Bits 7..5 = 001 clear the most urgent in-service bit. Bits 7..5 = 011 clear the in-service bit named by bits 2..0. Any other code has no effect.
- R10: An even write with bits 4..3 = 01 and bit 1 = 1 selects the request register (bit 0 = 1) or the in-service register (bit 0 = 0) for even reads. With bit 1 = 0, the selection is unchanged.
- R11: Mode-word bit 1 enables automatic end-of-interrupt, in which an acknowledge leaves no in-service bit set.
- R12: Mode-word bit 4 enables special nesting, in which a request at the same level as the most urgent in-service level also raises the interrupt output.
- R13: If an acknowledge and a new rising edge on the same line fall in one cycle, the request bit stays set. If an acknowledge and an end-of-interrupt command fall in one cycle, both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 1 | Port select: 0 even, 1 odd |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt request to the processor |
| inta | input | 1 | One-cycle acknowledge pulse |
| vec_out | output | 8 | Vector byte |
| vec_valid | output | 1 | vec_out holds a vector |

## Verification
Two pairs of functions can land in the same clock cycle. The first is an acknowledge together with a fresh edge on the line being acknowledged. The second is an acknowledge together with a specific end-of-interrupt write. The bench forces each pair by driving inta and the other stimulus on the same falling edge. It then reads the request and in-service registers back through the even port, after switching the read selection. For the first pair, the request bit must still be set and the new in-service bit present. For the second pair, the named in-service bit must be gone while the newly acknowledged one is set.

// File: rtl/prio_intc.sv
module prio_intc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic [7:0] irq_in,
  output logic       int_out,
  input  logic       inta,
  output logic [7:0] vec_out,
  output logic       vec_valid
);
  localparam int LW = 3;
  localparam int NL = 1 << LW;

  typedef enum logic [1:0] {ST_RUN, ST_W2, ST_W3, ST_W4} seq_t;

  function automatic logic [LW:0] first_set(input logic [NL-1:0] v);
    first_set = (LW+1)'(NL);
    for (int i = NL-1; i >= 0; i--)
      if (v[i]) first_set = (LW+1)'(i);
  endfunction

  seq_t            st;
  logic [NL-1:0]   irq_q, irr, isr, mask;
  logic [7-LW:0]   vbase;
  logic            ready, need4, single, aeoi, sfnm, rd_irr;
  logic [7:0]      vec_q;
  logic            vec_v;
  logic [LW:0]     top_req, top_svc;
  logic [NL-1:0]   grant_bit, eoi_clr;

  wire wr_even = wr_en & ~addr;
  wire wr_odd  = wr_en & addr;
  wire init1   = wr_even & wdata[4];
  wire cmd_ok  = wr_even & ~wdata[4] & ready;
  wire eoi_wr  = cmd_ok & ~wdata[3];
  wire sel_wr  = cmd_ok & wdata[3] & wdata[1];
  wire [NL-1:0] rise = irq_in & ~irq_q;

  assign top_req = first_set(irr & ~mask);
  assign top_svc = first_set(isr);
  assign int_out = ready & ~top_req[LW] &
                   (sfnm ? (top_req <= top_svc) : (top_req < top_svc));

  wire ack   = inta & ready;
  wire grant = ack & int_out;
  assign grant_bit = grant ? (NL'(1) << top_req[LW-1:0]) : '0;

  always_comb begin
    eoi_clr = '0;
    if (eoi_wr) begin
      case (wdata[7:5])
        3'b001: if (!top_svc[LW]) eoi_clr = NL'(1) << top_svc[LW-1:0];
        3'b011: eoi_clr = NL'(1) << wdata[LW-1:0];
        default: eoi_clr = '0;
      endcase
    end
  end

  assign rdata     = addr ? mask : (rd_irr ? irr : isr);
  assign vec_out   = vec_q;
  assign vec_valid = vec_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_RUN;  irq_q <= '0;  irr <= '0;  isr <= '0;  mask <= '0;
      vbase <= '0;   ready <= 1'b0; need4 <= 1'b0; single <= 1'b0;
      aeoi <= 1'b0;  sfnm <= 1'b0;  rd_irr <= 1'b1;
      vec_q <= '0;   vec_v <= 1'b0;
    end else begin
      irq_q <= irq_in;
      vec_v <= ack;
      vec_q <= ack ? {vbase, grant ? top_req[LW-1:0] : LW'(NL-1)} : 8'h00;
      if (init1) begin
        st <= ST_W2;  need4 <= wdata[0];  single <= wdata[1];
        ready <= 1'b0; irr <= '0; isr <= '0; mask <= '0;
        rd_irr <= 1'b1; aeoi <= 1'b0; sfnm <= 1'b0;
      end else begin
        irr <= (irr & ~grant_bit) | rise;
        isr <= (isr & ~eoi_clr) | (aeoi ? '0 : grant_bit);
        if (sel_wr) rd_irr <= wdata[0];
        if (wr_odd) begin
          case (st)
            ST_RUN: mask <= wdata;
            ST_W2: begin
              vbase <= wdata[7:LW];
              if (!single)    st <= ST_W3;
              else if (need4) st <= ST_W4;
              else begin st <= ST_RUN; ready <= 1'b1; end
            end
            ST_W3: begin
              if (need4) st <= ST_W4;
              else begin st <= ST_RUN; ready <= 1'b1; end
            end
            ST_W4: begin
              aeoi  <= wdata[1];
              sfnm  <= wdata[4];
              st    <= ST_RUN;
              ready <= 1'b1;
            end
            default: st <= ST_RUN;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/prio_intc_chk.sv
module prio_intc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       inta,
  input logic       int_out,
  input logic [7:0] vec_out,
  input logic       vec_valid,
  input logic [7:0] irr,
  input logic [7:0] isr,
  input logic [7:0] mask,
  input logic       ready,
  input logic       aeoi
);
  a_r2_quiet_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !int_out);

  a_r3_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (irr == 8'h00 && isr == 8'h00 && mask == 8'h00));

  a_r5_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr & ~mask) != 8'h00));

  a_r7_vec_follows_inta: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(inta));

  a_r7_vec_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid |-> (vec_out == 8'h00));

  a_r7_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && int_out && !aeoi && !(wr_en && !addr)) |=> (isr != 8'h00));

  a_r11_auto_eoi_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (aeoi && !wr_en) |=> (isr == $past(isr)));
endmodule

bind prio_intc prio_intc_chk u_chk (.*);

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] irq_in = 8'h00;
  logic       int_out;
  logic       inta = 1'b0;
  logic [7:0] vec_out;
  logic       vec_valid;

  int checks = 0;
  int fails  = 0;

  prio_intc dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_in(irq_in), .int_out(int_out), .inta(inta),
    .vec_out(vec_out), .vec_valid(vec_valid)
  );

  always #2.5 clk = ~clk;

  localparam int OW = 0, ORD = 1, OI = 2, OA = 3, OT = 4;

  function automatic logic [23:0] mk(input int op, input int a, input int d,
                                     input int e, input int t);
    return {3'(op), 1'(a), 8'(d), 8'(e), 4'(t)};
  endfunction

  localparam int NV = 37;
  localparam logic [23:0] VEC [NV] = '{
    mk(OW, 0, 8'h11, 0, 2),    // R2 opening word, slave map and mode word follow
    mk(OI, 0, 8'h08, 0, 2),    // line 3 rises during setup
    mk(OT, 0, 0, 0, 2),        // R2 no interrupt yet
    mk(OW, 1, 8'h40, 0, 2),    // base 01000
    mk(OW, 1, 8'h04, 0, 2),    // slave map word
    mk(OT, 0, 0, 0, 2),        // R2 still waiting for mode word
    mk(OW, 1, 8'h01, 0, 2),    // mode word
    mk(OT, 0, 0, 1, 6),        // R6 line 3 pending
    mk(ORD, 0, 0, 8'h08, 4),   // R4 request register
    mk(OA, 0, 0, 8'h43, 7),    // R7 vector
    mk(ORD, 0, 0, 8'h00, 7),   // R7 request cleared
    mk(OW, 0, 8'h0A, 0, 10),   // R10 select in-service
    mk(ORD, 0, 0, 8'h08, 7),   // R7 in-service set
    mk(OT, 0, 0, 0, 6),
    mk(OI, 0, 8'h28, 0, 6),    // line 5 rises
    mk(OT, 0, 0, 0, 6),        // R6 less urgent than in-service 3
    mk(OI, 0, 8'h2A, 0, 6),    // line 1 rises
    mk(OT, 0, 0, 1, 6),        // R6 more urgent
    mk(OA, 0, 0, 8'h41, 7),    // R7 nested vector
    mk(ORD, 0, 0, 8'h0A, 7),
    mk(OW, 0, 8'h20, 0, 9),    // R9 non-specific
    mk(ORD, 0, 0, 8'h08, 9),
    mk(OW, 0, 8'h40, 0, 9),    // R9 unused code
    mk(ORD, 0, 0, 8'h08, 9),
    mk(OW, 0, 8'h63, 0, 9),    // R9 specific level 3
    mk(ORD, 0, 0, 8'h00, 9),
    mk(OT, 0, 0, 1, 6),        // line 5 now served
    mk(OW, 1, 8'h20, 0, 5),    // R5 mask line 5
    mk(OT, 0, 0, 0, 5),
    mk(ORD, 1, 0, 8'h20, 5),
    mk(OW, 0, 8'h0B, 0, 10),   // R10 select request
    mk(ORD, 0, 0, 8'h20, 5),   // R5 still latched
    mk(OW, 0, 8'h08, 0, 10),   // R10 enable clear: no change
    mk(ORD, 0, 0, 8'h20, 10),
    mk(OA, 0, 0, 8'h47, 8),    // R8 spurious
    mk(ORD, 0, 0, 8'h20, 8),   // R8 untouched
    mk(OW, 1, 8'h00, 0, 5)
  };

  task automatic check(input logic ok, input int tag, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] e, input int tag);
    @(negedge clk); addr = a; #1;
    check(rdata == e, tag, rdata, e);
  endtask

  task automatic irq(input logic [7:0] v);
    @(negedge clk); irq_in = v;
    @(negedge clk);
  endtask

  task automatic ack(input logic [7:0] e, input int tag);
    @(negedge clk); inta = 1'b1;
    @(negedge clk); inta = 1'b0;
    check(vec_valid && vec_out == e, tag, vec_out, e);
  endtask

  task automatic int_chk(input logic e, input int tag);
    @(negedge clk);
    check(int_out == e, tag, {7'd0, int_out}, {7'd0, e});
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    check(!int_out && !vec_valid && vec_out == 8'h00, 1, vec_out, 8'h00);
    rd(0, 8'h00, 1);
    rd(1, 8'h00, 1);

    for (int i = 0; i < NV; i++) begin
      logic [2:0] op;
      logic       a;
      logic [7:0] d, e;
      int         t;
      {op, a, d, e} = VEC[i][23:4];
      t = int'(VEC[i][3:0]);
      case (int'(op))
        OW:  wr(a, d);
        ORD: rd(a, e, t);
        OI:  irq(d);
        OA:  ack(e, t);
        default: int_chk(e[0], t);
      endcase
    end

    // R3 opening word clears state and read selection
    wr(0, 8'h0A);
    ack(8'h45, 7);
    wr(1, 8'hF0);
    wr(0, 8'h13);
    rd(1, 8'h00, 3);
    rd(0, 8'h00, 3);
    int_chk(1'b0, 3);
    wr(1, 8'h80);
    wr(1, 8'h12);            // R2 single: this is the mode word (auto EOI, special nesting)
    irq(8'h00);
    irq(8'h04);
    rd(0, 8'h04, 3);         // R3 request register selected again
    ack(8'h82, 2);
    wr(0, 8'h0A);
    rd(0, 8'h00, 11);        // R11 nothing left in service

    // R12 special nesting
    wr(0, 8'h13); wr(1, 8'h80); wr(1, 8'h10);
    irq(8'h00);
    irq(8'h10);
    ack(8'h84, 7);
    irq(8'h00);
    irq(8'h10);
    int_chk(1'b1, 12);
    ack(8'h84, 12);

    // R13 acknowledge and fresh edge on the same line
    wr(0, 8'h13); wr(1, 8'h80); wr(1, 8'h01);
    irq(8'h00);
    irq(8'h40);
    irq(8'h00);
    @(negedge clk); inta = 1'b1; irq_in = 8'h40;
    @(negedge clk); inta = 1'b0;
    check(vec_valid && vec_out == 8'h86, 13, vec_out, 8'h86);
    @(negedge clk);
    check(!vec_valid && vec_out == 8'h00, 7, vec_out, 8'h00);   // R7 one cycle only
    rd(0, 8'h40, 13);
    int_chk(1'b0, 6);        // R6 equal level blocked when fully nested

    // R13 acknowledge together with a specific end-of-interrupt
    irq(8'h41);
    @(negedge clk); inta = 1'b1; addr = 1'b0; wdata = 8'h66; wr_en = 1'b1;
    @(negedge clk); inta = 1'b0; wr_en = 1'b0;
    check(vec_valid && vec_out == 8'h80, 13, vec_out, 8'h80);
    wr(0, 8'h0A);
    rd(0, 8'h01, 13);
    wr(0, 8'h0B);
    rd(0, 8'h40, 4);         // R4 held line 0 not re-latched
    int_chk(1'b0, 6);

    summary();
    $finish;
  end
endmodule